// File: doc/BRIEF.md
# Microcoded Bus Waveform Sequencer

This block steps through a small RAM of pattern words to shape the control waveform of an external memory bus cycle. It runs on a clock four times the bus clock, so each bus period is four quarter phases. Each pattern word gives every general-purpose line one level for the first half of the period (quarters 0 and 1) and one level for the second half (quarters 2 and 3). A word can run for one to four bus periods. A range of words marked by a pair of loop bits can run again a number of times set by the mode inputs. A last-word bit ends the run.

The highest-numbered line is shared. In output mode it is driven like the others. In wait mode it is read as a wait input instead. Its two bits in each word then become a sample-timing select and a wait enable. A wait that is enabled and asserted freezes the whole sequence until the wait is released. Software fills the RAM while the block is idle, sets the mode inputs, and then pulses start with a start address.

The control machine has three states. `ST_IDLE` goes to `ST_RUN` on start. `ST_RUN` stays in `ST_RUN` on each quarter step, each repeat, each loop jump-back and each stall. `ST_RUN` goes to `ST_FINISH` when a word with the last bit completes its final repeat. `ST_FINISH` always goes back to `ST_IDLE` after one cycle.

Top module: `bus_wave_seq`

## Requirements
- R1: After reset the block is in `ST_IDLE`. While idle, all of `gpl_o`, `sample_o` and `done_o` are 0.
- R2: Word layout. Bits [1:0] hold the repeat field, bit 2 the loop marker and bit 3 the last-word marker. Line k uses bit 4+2k for its first-half level and bit 5+2k for its second-half level. While running, line k shows its first-half bit in quarters 0 and 1 and its second-half bit in quarters 2 and 3. The quarter advances by one each clock.
- R3: A repeat field of 0, 1, 2 or 3 makes the word run for 1, 2, 3 or 4 bus periods.
- R4: A loop is opened by the first loop-marked word that is entered while no loop is open. The next loop-marked word at a different address closes it. The loop counter is loaded from `mode_loops_i` only on the first entry. The body runs `mode_loops_i`+1 times, then execution continues after the closing word.
- R5: When a last-marked word finishes its final repeat, the next cycle drives `done_o` high for exactly one cycle with all lines low. The block is then idle.
- R6: Start loads the word address from `start_addr_i`. Execution then moves to the next address and wraps from the top address to 0.
- R7: A start pulse received while the block is not idle has no effect on the running sequence.
- R8: RAM writes take effect only in `ST_IDLE`. Writes at any other time are dropped.
- R9: In wait mode (`mode_wait_i`=1) the shared line NLINE-1 is held at 0, its second-half bit is the wait enable, and its first-half bit is the sample select. If the enable is 1 and `wait_i` is 1, the outputs, quarter, repeat count, loop state and address all hold, and no sample strobe is issued. If the enable is 0, or in output mode, `wait_i` is ignored.
- R10: `sample_o` pulses once per bus period of each word. It pulses in quarter 2 of that period if the block is in wait mode and the sample select is 1. Otherwise it pulses in quarter 0 of the following cycle, which is the done cycle for the final period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Quarter-phase clock (4x bus clock) |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Pattern RAM write strobe |
| wr_addr_i | input | AW | Pattern RAM write address |
| wr_data_i | input | 4+2*NLINE | Pattern word to write |
| mode_wait_i | input | 1 | 1: shared line acts as wait input |
| mode_loops_i | input | LCW | Extra loop-body passes |
| start_addr_i | input | AW | First word address |
| start_i | input | 1 | Start strobe |
| wait_i | input | 1 | External wait level |
| gpl_o | output | NLINE | General-purpose line levels |
| sample_o | output | 1 | Read-data sample strobe |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
Each program's expected trace is built in the bench by walking the words under the requirements. The trace is then compared cycle by cycle for lines, strobe and done. A straight program with mixed repeats and line patterns checks the half-period level selection and repeat counting. A sweep of all four loop counts against all four repeat values of a loop-body word separates loop reload from loop counting. A wrapped program started near the top checks the start address and the address roll-over. Wait runs with the enable both set and clear, and in both modes, separate a real freeze from an ignored wait and early strobes from late ones. A busy-time start and write, followed by a rerun, shows both are dropped.

// File: rtl/bus_wave_seq_pkg.sv
package bus_wave_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } seq_state_e;

    // fixed control field positions inside a pattern word
    localparam int RPT_LO    = 0;
    localparam int LOOP_POS  = 2;
    localparam int LAST_POS  = 3;
    localparam int LINE_BASE = 4;

endpackage

// File: rtl/bws_pattern_ram.sv
module bws_pattern_ram #(
    parameter int AW = 4,
    parameter int WW = 12
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [WW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [WW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [WW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/bws_loop_track.sv
module bws_loop_track #(
    parameter int AW  = 4,
    parameter int LCW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           running,
    input  logic           word_done,
    input  logic           loop_bit,
    input  logic [AW-1:0]  addr,
    input  logic [LCW-1:0] mode_cnt,
    output logic           take_back,
    output logic [AW-1:0]  start_addr
);
    logic           in_loop;
    logic [LCW-1:0] count;
    logic           is_end;

    assign is_end    = in_loop && loop_bit && (addr != start_addr);
    assign take_back = is_end && (count != '0);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            in_loop    <= 1'b0;
            count      <= '0;
            start_addr <= '0;
        end else if (running && !in_loop && loop_bit) begin
            in_loop    <= 1'b1;
            start_addr <= addr;
            count      <= mode_cnt;
        end else if (word_done && is_end) begin
            if (count != '0) begin
                count <= count - 1'b1;
            end else begin
                in_loop <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/bws_line_drive.sv
module bws_line_drive #(
    parameter int NLINE = 4
) (
    input  logic               active,
    input  logic               second_half,
    input  logic               wait_mode,
    input  logic [2*NLINE-1:0] line_bits,
    output logic [NLINE-1:0]   lines
);
    for (genvar k = 0; k < NLINE; k++) begin : g_line
        if (k == NLINE - 1) begin : g_shared
            assign lines[k] = active && !wait_mode &&
                              (second_half ? line_bits[2*k+1] : line_bits[2*k]);
        end else begin : g_plain
            assign lines[k] = active &&
                              (second_half ? line_bits[2*k+1] : line_bits[2*k]);
        end
    end

endmodule

// File: rtl/bus_wave_seq.sv
module bus_wave_seq
    import bus_wave_seq_pkg::*;
#(
    parameter int AW    = 4,
    parameter int NLINE = 4,
    parameter int LCW   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [AW-1:0]        wr_addr_i,
    input  logic [4+2*NLINE-1:0] wr_data_i,
    input  logic                 mode_wait_i,
    input  logic [LCW-1:0]       mode_loops_i,
    input  logic [AW-1:0]        start_addr_i,
    input  logic                 start_i,
    input  logic                 wait_i,
    output logic [NLINE-1:0]     gpl_o,
    output logic                 sample_o,
    output logic                 done_o
);
    localparam int WW     = LINE_BASE + 2 * NLINE;
    localparam int SEL_POS = LINE_BASE + 2 * (NLINE - 1);
    localparam int WEN_POS = SEL_POS + 1;

    seq_state_e    state, state_nx;
    logic [AW-1:0] addr;
    logic [1:0]    qph;
    logic [1:0]    rep_cnt;
    logic          pend;
    logic [WW-1:0] word;
    logic [1:0]    rpt;
    logic          run, fin, go, stall, early;
    logic          period_end, rep_done, word_end, take_back;
    logic [AW-1:0] loop_start;
    logic [NLINE-1:0] lines;

    assign run        = (state == ST_RUN);
    assign fin        = (state == ST_FINISH);
    assign go         = (state == ST_IDLE) && start_i;
    assign rpt        = word[RPT_LO+1:RPT_LO];
    assign early      = mode_wait_i && word[SEL_POS];
    assign stall      = run && mode_wait_i && word[WEN_POS] && wait_i;
    assign period_end = run && !stall && (qph == 2'd3);
    assign rep_done   = (rep_cnt == rpt);
    assign word_end   = period_end && rep_done;

    bws_pattern_ram #(.AW(AW), .WW(WW)) u_ram (
        .clk   (clk),
        .we    (wr_en_i && (state == ST_IDLE)),
        .waddr (wr_addr_i),
        .wdata (wr_data_i),
        .raddr (addr),
        .rdata (word)
    );

    bws_loop_track #(.AW(AW), .LCW(LCW)) u_loop (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (go),
        .running    (run),
        .word_done  (word_end && !word[LAST_POS]),
        .loop_bit   (word[LOOP_POS]),
        .addr       (addr),
        .mode_cnt   (mode_loops_i),
        .take_back  (take_back),
        .start_addr (loop_start)
    );

    bws_line_drive #(.NLINE(NLINE)) u_lines (
        .active      (run),
        .second_half (qph[1]),
        .wait_mode   (mode_wait_i),
        .line_bits   (word[WW-1:LINE_BASE]),
        .lines       (lines)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start_i) state_nx = ST_RUN;
            ST_RUN:    if (word_end && word[LAST_POS]) state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // sequencing datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr    <= '0;
            qph     <= '0;
            rep_cnt <= '0;
            pend    <= 1'b0;
        end else if (go) begin
            addr    <= start_addr_i;
            qph     <= '0;
            rep_cnt <= '0;
            pend    <= 1'b0;
        end else if (run && !stall) begin
            qph  <= qph + 2'd1;
            pend <= (qph == 2'd3) && !early;
            if (qph == 2'd3) begin
                if (!rep_done) begin
                    rep_cnt <= rep_cnt + 2'd1;
                end else begin
                    rep_cnt <= '0;
                    if (!word[LAST_POS]) begin
                        addr <= take_back ? loop_start : addr + 1'b1;
                    end
                end
            end
        end else if (fin) begin
            pend <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        gpl_o    = lines;
        done_o   = fin;
        sample_o = ((run || fin) && pend && !stall) ||
                   (run && !stall && (qph == 2'd2) && early);
    end

endmodule

// File: rtl/bus_wave_seq_chk.sv
module bus_wave_seq_chk
    import bus_wave_seq_pkg::*;
#(
    parameter int AW    = 4,
    parameter int NLINE = 4
) (
    input logic             clk,
    input logic             rst_n,
    input seq_state_e       state,
    input logic [AW-1:0]    addr,
    input logic [1:0]       qph,
    input logic [1:0]       rep_cnt,
    input logic [1:0]       rpt,
    input logic             stall,
    input logic             mode_wait_i,
    input logic             start_i,
    input logic [NLINE-1:0] gpl_o,
    input logic             sample_o,
    input logic             done_o
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (gpl_o == '0 && !sample_o && !done_o));

    p_quarter_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !stall) |=> (qph == $past(qph) + 2'd1));

    p_rep_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (rep_cnt <= rpt));

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_lines_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (gpl_o == '0));

    p_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && start_i && !stall && qph != 2'd3) |=> $stable(addr));

    p_freeze_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(addr) && $stable(qph) && $stable(rep_cnt)));

    p_freeze_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !sample_o);

    p_shared_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wait_i |-> !gpl_o[NLINE-1]);

endmodule

bind bus_wave_seq bus_wave_seq_chk #(.AW(AW), .NLINE(NLINE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .addr        (addr),
    .qph         (qph),
    .rep_cnt     (rep_cnt),
    .rpt         (rpt),
    .stall       (stall),
    .mode_wait_i (mode_wait_i),
    .start_i     (start_i),
    .gpl_o       (gpl_o),
    .sample_o    (sample_o),
    .done_o      (done_o)
);

// File: tb/bus_wave_seq_test.sv
module bus_wave_seq_test;
    localparam int AW = 3, NLINE = 3, LCW = 2;
    localparam int WW = 4 + 2 * NLINE, SH = NLINE - 1, DEPTH = 1 << AW;
    localparam int MAXC = 400;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0, mode_wait = 1'b0, start = 1'b0, wait_in = 1'b0;
    logic [AW-1:0] wr_addr = '0, start_addr = '0;
    logic [WW-1:0] wr_data = '0;
    logic [LCW-1:0] mode_loops = '0;
    logic [NLINE-1:0] gpl;
    logic sample, done;

    int nchk = 0, nfail = 0;
    logic [WW-1:0] prog [DEPTH];
    logic wsch [MAXC];
    logic [NLINE-1:0] eg [MAXC];
    logic es [MAXC];
    logic ed [MAXC];
    int elen;

    always #4 clk = ~clk;

    bus_wave_seq #(.AW(AW), .NLINE(NLINE), .LCW(LCW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .mode_wait_i(mode_wait), .mode_loops_i(mode_loops),
        .start_addr_i(start_addr), .start_i(start), .wait_i(wait_in),
        .gpl_o(gpl), .sample_o(sample), .done_o(done));

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // lk: bit0 first-half level, bit1 second-half level
    function automatic logic [WW-1:0] mkw(input int rp, input bit lp, input bit last,
                                          input int l0, input int l1, input int l2);
        logic [WW-1:0] w = '0;
        w[1:0] = rp[1:0]; w[2] = lp; w[3] = last;
        w[5:4] = l0[1:0]; w[7:6] = l1[1:0]; w[9:8] = l2[1:0];
        return w;
    endfunction

    task automatic clear_wait();
        for (int i = 0; i < MAXC; i++) wsch[i] = 1'b0;
    endtask

    task automatic build_expect(input int sa);
        int a = sa, q = 0, r = 0, lst = 0, lc = 0, c = 0;
        bit inl = 0, pend = 0, fin = 0, st, early;
        logic [WW-1:0] w;
        logic [NLINE-1:0] g;
        while (!fin && c < MAXC - 1) begin
            w = prog[a];
            if (!inl && w[2]) begin inl = 1; lst = a; lc = int'(mode_loops); end
            st = mode_wait && w[5+2*SH] && wsch[c];
            early = mode_wait && w[4+2*SH];
            for (int k = 0; k < NLINE; k++)
                g[k] = (k == SH && mode_wait) ? 1'b0 : ((q < 2) ? w[4+2*k] : w[5+2*k]);
            eg[c] = g; ed[c] = 1'b0;
            es[c] = (pend && !st) || (!st && q == 2 && early);
            if (!st) begin
                pend = (q == 3) && !early;
                if (q == 3) begin
                    if (r != int'(w[1:0])) r++;
                    else begin
                        r = 0;
                        if (w[3]) fin = 1;
                        else if (inl && w[2] && a != lst) begin
                            if (lc != 0) begin lc--; a = lst; end
                            else begin inl = 0; a = (a + 1) % DEPTH; end
                        end else a = (a + 1) % DEPTH;
                    end
                end
                q = (q + 1) % 4;
            end
            c++;
        end
        eg[c] = '0; es[c] = pend; ed[c] = 1'b1;
        elen = c + 1;
    endtask

    task automatic load_prog();
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk); wr_en = 1'b1; wr_addr = AW'(i); wr_data = prog[i];
        end
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic run(input string req, input int sa, input int poke);
        build_expect(sa);
        @(negedge clk); start_addr = AW'(sa); start = 1'b1;
        for (int c = 0; c < elen; c++) begin
            @(negedge clk);
            start = 1'b0; wr_en = 1'b0;
            if (c == poke) begin
                start = 1'b1; start_addr = ~AW'(sa);
                wr_en = 1'b1; wr_addr = '0; wr_data = ~prog[0];
            end
            wait_in = wsch[c];
            #1;
            check(req, int'(gpl), int'(eg[c]));
            check(req, int'(sample), int'(es[c]));
            check(req, int'(done), int'(ed[c]));
        end
        @(negedge clk); start = 1'b0; wr_en = 1'b0; wait_in = 1'b0; #1;
        check("R5", int'(done), 0);
        check("R5", int'(gpl), 0);
    endtask

    initial begin
        #(8 * 150000);
        nfail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        clear_wait();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R1", int'(gpl), 0); check("R1", int'(done), 0); check("R1", int'(sample), 0);

        // straight program: R2 R3 R5 R10, repeat sweep on word 1
        for (int rp = 0; rp < 4; rp++) begin
            for (int i = 0; i < DEPTH; i++) prog[i] = mkw(0, 0, 0, 0, 0, 0);
            prog[0] = mkw(0, 0, 0, 1, 2, 3);
            prog[1] = mkw(rp, 0, 0, 2, 3, 0);
            prog[2] = mkw(3, 0, 1, 3, 1, 2);
            load_prog();
            mode_wait = 1'b0; mode_loops = '0;
            run("R3", 0, -1);
        end

        // loop sweep: R4
        for (int lp = 0; lp < 4; lp++) begin
            for (int rp = 0; rp < 4; rp++) begin
                for (int i = 0; i < DEPTH; i++) prog[i] = mkw(0, 0, 0, 0, 0, 0);
                prog[0] = mkw(0, 0, 0, 1, 0, 0);
                prog[1] = mkw(rp, 1, 0, 2, 1, 0);
                prog[2] = mkw(0, 0, 0, 3, 0, 1);
                prog[3] = mkw(0, 1, 0, 0, 3, 2);
                prog[4] = mkw(1, 0, 1, 1, 1, 1);
                load_prog();
                mode_loops = LCW'(lp);
                run("R4", 0, -1);
            end
        end

        // start address and wrap: R6
        for (int i = 0; i < DEPTH; i++) prog[i] = mkw(0, 0, 0, 0, 0, 0);
        prog[6] = mkw(0, 0, 0, 2, 1, 3);
        prog[7] = mkw(1, 0, 0, 1, 2, 0);
        prog[0] = mkw(0, 0, 1, 3, 3, 1);
        prog[1] = mkw(0, 0, 1, 1, 1, 1);
        load_prog();
        mode_loops = '0;
        run("R6", 6, -1);

        // busy start and busy write dropped: R7 then R8 rerun
        run("R7", 6, 2);
        run("R8", 6, -1);

        // wait mode: R9 R10
        for (int i = 0; i < DEPTH; i++) prog[i] = mkw(0, 0, 0, 0, 0, 0);
        prog[0] = mkw(0, 0, 0, 1, 2, 3);   // select 1, enable 1
        prog[1] = mkw(1, 0, 0, 2, 1, 2);   // select 0, enable 1
        prog[2] = mkw(0, 0, 1, 3, 3, 1);   // select 1, enable 0
        load_prog();
        mode_wait = 1'b1;
        run("R10", 0, -1);
        clear_wait();
        wsch[2] = 1; wsch[3] = 1; wsch[4] = 1; wsch[9] = 1;
        wsch[14] = 1; wsch[15] = 1;
        for (int i = 18; i < 30; i++) wsch[i] = 1;
        run("R9", 0, -1);
        mode_wait = 1'b0;
        run("R9", 0, -1);
        clear_wait();

        @(negedge clk); #1;
        check("R1", int'(gpl), 0);
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule